// File: doc/BRIEF.md
# Symmetric Square-Wave Clock Divider

The block takes one source clock and produces a square wave at the source frequency divided by an integer parameter `N`. The high and low phases of the output are equal for every `N`. For even ratios both output transitions sit on rising source edges. For odd ratios the output must change at half-cycle points. A rising-edge stage builds a waveform that is one half-cycle too wide. A falling-edge stage retimes that waveform by half a cycle. The output is the AND of the two stages, and the odd ratio comes out symmetric.

The output is meant for an output pin or a clock-management cell only. Logic inside the chip that needs a slower rate must use a one-cycle enable on the source clock, and must never be clocked by this output. Reset is synchronous and active-high, and it holds the output low. `N = 1` gates the source clock straight through. `N = 2` reduces to a single toggling flop.

Top module: `sym_clk_divider`

## Requirements
- R1: For even N the output is high for N/2 source cycles and low for N/2 source cycles, and both transitions occur just after a rising source edge.
- R2: The ratio counter steps from 0 up to N-1 and then wraps to 0, so one output period spans exactly N source cycles (2N half-cycles), never N+1.
- R3: For odd N greater than 1 the output is high for N half-cycles and low for N half-cycles (1.5 cycles each for N=3).
- R4: For odd N greater than 1 the output rises just after a falling source edge and falls just after a rising source edge, because the falling-edge stage copies the rising-edge waveform half a cycle later and the output is their AND.
- R5: With N=1 the output follows the source clock (high in the high half, low in the low half) once out of reset.
- R6: While reset is held across a rising source edge, the output is low from then on until reset is released.
- R7: Right after reset is released the output is low, and its first rising transition comes within 2N half-cycles.
- R8: A reset that lands on the counter's wrap edge keeps the output low, and after release the first high phase has its full length of N half-cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock, the only clock of the block |
| rst | input | 1 | Synchronous active-high reset |
| clk_out | output | 1 | Divided square wave with equal high and low phases |

## Verification
The reset and the counter wrap can fall on the same rising edge, the edge where the output would otherwise start a new high phase. The bench releases reset on a known edge and counts rising edges to reach the wrap edge of the N=3 instance. It asserts reset so that reset is sampled on exactly that edge, then checks that every divider's output stays low. After the next release it checks that the first high phase still measures its full N half-cycles. Widths are measured by sampling the output a quarter-cycle after every source edge. The source clock level at a transition shows which edge moved the output.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_EVEN = 2'd1,
    MODE_ODD  = 2'd2
  } div_mode_e;

  // bits needed to hold 0 .. n-1
  function automatic int cnt_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // rising-edge stage high length in source cycles: n/2 for even, (n+1)/2 for odd
  function automatic int high_span(input int n);
    return (n + 1) / 2;
  endfunction

  function automatic div_mode_e pick_mode(input int n);
    if (n <= 1)            return MODE_PASS;
    else if ((n % 2) == 0) return MODE_EVEN;
    else                   return MODE_ODD;
  endfunction

endpackage

// File: rtl/div_mod_counter.sv
module div_mod_counter #(
  parameter int N = 3,
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt
);

  localparam logic [W-1:0] LAST = W'(N - 1);

  logic at_last;
  assign at_last = (cnt == LAST);
  assign cnt_nxt = at_last ? '0 : cnt + W'(1);

  // reset parks at the terminal value so the first edge after release starts at 0
  always_ff @(posedge clk) begin
    if (rst) cnt <= LAST;
    else     cnt <= cnt_nxt;
  end

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (cnt == LAST) |=> (cnt == '0)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (cnt != LAST) |=> (cnt == $past(cnt) + W'(1))); // R2

endmodule

// File: rtl/div_rise_stage.sv
module div_rise_stage #(
  parameter int W  = 2,
  parameter int HI = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cnt_nxt,
  output logic         rise_q
);

  localparam logic [W-1:0] HI_V = W'(HI);

  logic want_high;
  assign want_high = (cnt_nxt < HI_V);

  always_ff @(posedge clk) begin
    if (rst) rise_q <= 1'b0;
    else     rise_q <= want_high;
  end

  AST_RISE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(rise_q) |-> (cnt == '0)); // R2
  AST_FALL_AT_SPAN: assert property (@(posedge clk) disable iff (rst)
    $fell(rise_q) |-> (cnt == HI_V)); // R1

endmodule

// File: rtl/div_fall_stage.sv
module div_fall_stage (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  always_ff @(negedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end

endmodule

// File: rtl/sym_clk_divider.sv
module sym_clk_divider #(
  parameter int N = 3
) (
  input  logic clk_src,
  input  logic rst,
  output logic clk_out
);

  import clkdiv_pkg::*;

  localparam div_mode_e MODE = pick_mode(N);

  generate
    if (MODE == MODE_PASS) begin : g_pass
      logic pass_en;
      // enable changes only while the source clock is low
      div_fall_stage u_gate (
        .clk(clk_src), .rst(rst), .d(1'b1), .q(pass_en)
      );
      assign clk_out = clk_src & pass_en;
    end else if (MODE == MODE_EVEN) begin : g_even
      localparam int W  = cnt_w(N);
      localparam int HI = high_span(N);
      logic [W-1:0] cnt, cnt_nxt;
      logic         rise_q;
      div_mod_counter #(.N(N), .W(W)) u_cnt (
        .clk(clk_src), .rst(rst), .cnt(cnt), .cnt_nxt(cnt_nxt)
      );
      div_rise_stage #(.W(W), .HI(HI)) u_rise (
        .clk(clk_src), .rst(rst), .cnt(cnt), .cnt_nxt(cnt_nxt), .rise_q(rise_q)
      );
      assign clk_out = rise_q;
    end else begin : g_odd
      localparam int W  = cnt_w(N);
      localparam int HI = high_span(N);
      logic [W-1:0] cnt, cnt_nxt;
      logic         rise_q, fall_q;
      div_mod_counter #(.N(N), .W(W)) u_cnt (
        .clk(clk_src), .rst(rst), .cnt(cnt), .cnt_nxt(cnt_nxt)
      );
      div_rise_stage #(.W(W), .HI(HI)) u_rise (
        .clk(clk_src), .rst(rst), .cnt(cnt), .cnt_nxt(cnt_nxt), .rise_q(rise_q)
      );
      div_fall_stage u_fall (
        .clk(clk_src), .rst(rst), .d(rise_q), .q(fall_q)
      );
      // the wide phase trimmed by the half-cycle lag of the falling-edge copy
      assign clk_out = rise_q & fall_q;

      AST_FALL_TRACKS: assert property (@(posedge clk_src) disable iff (rst)
        fall_q == rise_q); // R4
    end
  endgenerate

  AST_RESET_QUIET: assert property (@(posedge clk_src)
    rst |=> !clk_out); // R6

endmodule

// File: tb/sym_clk_divider_tb_top.sv
module sym_clk_divider_tb_top;

  localparam int NUM = 6;
  localparam int NS [NUM] = '{3, 1, 2, 4, 5, 7};

  logic           clk_src = 1'b0;
  logic           rst     = 1'b1;
  logic [NUM-1:0] outs;
  int total = 0;
  int fails = 0;
  bit done  = 0;

  always #4 clk_src = ~clk_src;

  sym_clk_divider #(.N(3)) dut_i   (.clk_src(clk_src), .rst(rst), .clk_out(outs[0]));
  sym_clk_divider #(.N(1)) dut_n1_i (.clk_src(clk_src), .rst(rst), .clk_out(outs[1]));
  sym_clk_divider #(.N(2)) dut_n2_i (.clk_src(clk_src), .rst(rst), .clk_out(outs[2]));
  sym_clk_divider #(.N(4)) dut_n4_i (.clk_src(clk_src), .rst(rst), .clk_out(outs[3]));
  sym_clk_divider #(.N(5)) dut_n5_i (.clk_src(clk_src), .rst(rst), .clk_out(outs[4]));
  sym_clk_divider #(.N(7)) dut_n7_i (.clk_src(clk_src), .rst(rst), .clk_out(outs[5]));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic half_step();
    @(posedge clk_src or negedge clk_src);
    #2;
  endtask

  // sync to a rising output transition, then measure phases in half-cycles
  task automatic measure(input int idx, input int periods, input string req);
    int n = NS[idx];
    int hi, lo, guard;
    logic prev;
    bit found = 0;
    int rise_lvl = ((n % 2) == 1 && n > 1) ? 0 : 1;   // source level after the rising transition
    int fall_lvl = (n == 1) ? 0 : 1;                  // source level after the falling transition
    half_step();
    prev = outs[idx];
    for (int g = 0; g < 4 * n + 4; g++) begin
      half_step();
      if (!prev && outs[idx]) begin found = 1; break; end
      prev = outs[idx];
    end
    check(found, req, $sformatf("N=%0d rising transition seen", n), found, 1);
    if (!found) return;
    for (int p = 0; p < periods; p++) begin
      check(int'(clk_src) == rise_lvl, "R4", $sformatf("N=%0d source level at output rise", n),
            int'(clk_src), rise_lvl);
      hi = 1; guard = 0;
      while (guard < 4 * n) begin
        half_step(); guard++;
        if (outs[idx]) hi++; else break;
      end
      check(int'(clk_src) == fall_lvl, "R4", $sformatf("N=%0d source level at output fall", n),
            int'(clk_src), fall_lvl);
      lo = 1; guard = 0;
      while (guard < 4 * n) begin
        half_step(); guard++;
        if (!outs[idx]) lo++; else break;
      end
      check(hi == n, req, $sformatf("N=%0d high half-cycles", n), hi, n);
      if (periods > 1) begin
        check(lo == n, req, $sformatf("N=%0d low half-cycles", n), lo, n);
        check(hi + lo == 2 * n, "R2", $sformatf("N=%0d period half-cycles", n), hi + lo, 2 * n);
      end
    end
  endtask

  task automatic test_reset_state();
    bit all_low = 1;
    rst = 1'b1;
    repeat (3) @(posedge clk_src);
    for (int s = 0; s < 6; s++) begin
      half_step();
      if (outs != '0) all_low = 0;
    end
    check(all_low, "R6", "outputs low in reset", int'(outs), 0);
  endtask

  task automatic test_startup();
    int first [NUM];
    for (int i = 0; i < NUM; i++) first[i] = -1;
    @(posedge clk_src); #2;
    rst = 1'b0;
    check(outs == '0, "R7", "outputs low at release", int'(outs), 0);
    for (int s = 1; s <= 16; s++) begin
      half_step();
      for (int i = 0; i < NUM; i++)
        if (first[i] < 0 && outs[i]) first[i] = s;
    end
    for (int i = 0; i < NUM; i++)
      check(first[i] > 0 && first[i] <= 2 * NS[i], "R7",
            $sformatf("N=%0d half-cycles to first rise", NS[i]), first[i], 2 * NS[i]);
  endtask

  task automatic test_ratios();
    measure(0, 3, "R3");   // N=3
    measure(1, 3, "R5");   // N=1
    measure(2, 3, "R1");   // N=2
    measure(3, 3, "R1");   // N=4
    measure(4, 3, "R3");   // N=5
    measure(5, 3, "R3");   // N=7
  endtask

  // reset sampled on the wrap edge of the N=3 divider (rising edge 1+3 after release)
  task automatic test_reset_on_wrap(input int idx);
    bit all_low = 1;
    rst = 1'b1;
    repeat (2) @(posedge clk_src);
    #2; rst = 1'b0;
    repeat (3) @(posedge clk_src);
    #2; rst = 1'b1;
    @(posedge clk_src); #2;
    if (outs != '0) all_low = 0;
    half_step();
    if (outs != '0) all_low = 0;
    check(all_low, "R8", "outputs low with reset on wrap edge", int'(outs), 0);
    @(posedge clk_src); #2;
    rst = 1'b0;
    measure(idx, 1, "R8");
  endtask

  initial begin
    test_reset_state();
    test_startup();
    test_ratios();
    for (int i = 0; i < NUM; i++) test_reset_on_wrap(i);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
    end
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL R2 watchdog: actual 0 expected 1 (run completed)");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule